// File: doc/BRIEF.md
# Open-Row DRAM Bank Timing Model

This block stands in for a single DRAM bank that runs an open-row policy. A requester presents one access at a time (read or write, a row number and a column number) over a valid/ready handshake. The bank keeps exactly one row open in a row buffer, which behaves like a one-entry cache in front of the cell array. Each access is classified against that buffer and answered after a latency that depends on the class.

There are three classes. An access to the row already in the buffer is a *hit* and needs only the column latency. An access to a different row is a *conflict*: the buffer is first written back to its row, and then the new row is activated and copied into the buffer. The first access after reset finds no open row and is a *miss*, which pays activation but no write-back. Column reads and writes are always served from the buffer. The cells only see new data when a row is written back. Two saturating counters record how many hits and conflicts have completed, and a synchronous clear input zeroes them.

The row number is 15 bits wide, so the bank has 32768 rows for classification. The behavioural cell store holds only `2**STORE_IDX_W` rows of data, and a row's data lives in the store slot given by its low `STORE_IDX_W` bits.

Top module: `dram_bank_model`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, both counters read 0, no row is open, and every cell reads 0.
- R2: The first access after reset is reported with `rsp_kind` = 2'b01 (miss), and `rsp_valid` rises ACT_LAT+HIT_LAT cycles after the accepting clock edge.
- R3: An access to the row currently open is reported with `rsp_kind` = 2'b00 (hit), with a latency of HIT_LAT cycles.
- R4: An access to any row other than the open one is reported with `rsp_kind` = 2'b10 (conflict), with a latency of PRE_LAT+ACT_LAT+HIT_LAT cycles. The accessed row is open afterwards.
- R5: All 15 bits of `req_row` take part in the hit test, so two rows that differ only in bit 14 conflict with each other.
- R6: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` stays 0 until the cycle after the response pulse. A request presented while `req_ready` is 0 is ignored: it produces no response and changes neither the open row nor any data.
- R7: Each accepted request produces exactly one `rsp_valid` pulse, one cycle long.
- R8: A read returns the addressed column of the accessed row in `rsp_rdata`. A write stores `req_wdata` into that column and returns the written value in `rsp_rdata`. A later read of the same column returns the written value.
- R9: Data written into the open row survives closing that row through a conflict and reopening it later.
- R10: Rows whose low STORE_IDX_W bits match share the same data cells, even though they are distinct rows for hit and conflict classification.
- R11: `hit_count` increases by one for each completed hit and `conflict_count` by one for each completed conflict. A miss changes neither. Each counter holds at 2**CNT_W-1 instead of wrapping.
- R12: `cnt_clear` zeroes both counters on the next edge, and it takes priority over an increment on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W (15) | Row number |
| req_col | input | COL_W (2) | Column number within the row |
| req_wdata | input | DATA_W (8) | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W (8) | Read data, or the written data for a write |
| rsp_kind | output | 2 | 00 hit, 01 miss, 10 conflict |
| cnt_clear | input | 1 | Synchronous clear of both counters |
| hit_count | output | CNT_W (4) | Saturating count of completed hits |
| conflict_count | output | CNT_W (4) | Saturating count of completed conflicts |

## Verification
The bench counts the cycles from the accepting edge to the response for every class. A design that treats the post-reset access as a conflict, or that charges a hit for activation, therefore shows up as a wrong latency or a wrong kind code. It closes a written row through a conflict and reopens it, so a design that drops the write-back returns stale zeros. It also compares rows that differ only in the top address bit, which catches a truncated row comparison. A request is poked while the bank is busy and the following access is then checked for the expected hit. Counters are driven past their maximum and cleared in the same cycle as an increment, exposing wrap-around and wrong clear priority.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

    typedef enum logic [1:0] {
        KIND_HIT      = 2'b00,
        KIND_MISS     = 2'b01,
        KIND_CONFLICT = 2'b10
    } dbm_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_RESP = 2'b10
    } dbm_state_e;

endpackage

// File: rtl/dbm_row_store.sv
module dbm_row_store #(
    parameter int IDX_W    = 3,
    parameter int ROW_BITS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [ROW_BITS-1:0] rd_row,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [ROW_BITS-1:0] wr_row
);
    localparam int SLOTS = 1 << IDX_W;

    logic [SLOTS-1:0][ROW_BITS-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_idx] = wr_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    // Whole-row read; the controller copies it into the buffer on activation.
    assign rd_row = mem_q[rd_idx];

endmodule

// File: rtl/dbm_sat_counter.sv
module dbm_sat_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clr) begin
            count_d = '0;
        end else if (inc && count_q != TOP) begin
            count_d = count_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

    assert_sat_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == TOP && !clr) |=> count_q == TOP);

    assert_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && count_q != TOP) |=> count_q == $past(count_q) + CNT_W'(1));

    assert_clear_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count_q == '0);

endmodule

// File: rtl/dbm_bank_ctrl.sv
module dbm_bank_ctrl
    import dbm_pkg::*;
#(
    parameter int ROW_W   = 15,
    parameter int COL_W   = 2,
    parameter int DATA_W  = 8,
    parameter int IDX_W   = 3,
    parameter int HIT_LAT = 2,
    parameter int ACT_LAT = 3,
    parameter int PRE_LAT = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_write,
    input  logic [ROW_W-1:0]              req_row,
    input  logic [COL_W-1:0]              req_col,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic                          rsp_valid,
    output logic [DATA_W-1:0]             rsp_rdata,
    output logic [1:0]                    rsp_kind,
    output logic [IDX_W-1:0]              st_rd_idx,
    input  logic [(DATA_W<<COL_W)-1:0]    st_rd_row,
    output logic                          st_wr_en,
    output logic [IDX_W-1:0]              st_wr_idx,
    output logic [(DATA_W<<COL_W)-1:0]    st_wr_row,
    output logic                          hit_done,
    output logic                          conflict_done
);
    localparam int NCOL     = 1 << COL_W;
    localparam int MISS_LAT = ACT_LAT + HIT_LAT;
    localparam int CONF_LAT = PRE_LAT + ACT_LAT + HIT_LAT;
    localparam int LAT_W    = $clog2(CONF_LAT + 1);
    localparam logic [LAT_W-1:0] HIT_CNT  = LAT_W'(HIT_LAT - 1);
    localparam logic [LAT_W-1:0] MISS_CNT = LAT_W'(MISS_LAT - 1);
    localparam logic [LAT_W-1:0] CONF_CNT = LAT_W'(CONF_LAT - 1);

    typedef logic [NCOL-1:0][DATA_W-1:0] row_t;

    typedef struct packed {
        dbm_state_e        state;
        logic [LAT_W-1:0]  cnt;
        logic              open_vld;
        logic [ROW_W-1:0]  open_row;
        row_t              rbuf;
        logic [DATA_W-1:0] rdata;
        dbm_kind_e         kind;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;
    row_t  act_row;
    logic  accept;

    assign accept    = req_valid && (cur_q.state == ST_IDLE);
    assign st_rd_idx = req_row[IDX_W-1:0];

    always_comb begin
        nxt_d     = cur_q;
        act_row   = cur_q.rbuf;
        st_wr_en  = 1'b0;
        st_wr_idx = cur_q.open_row[IDX_W-1:0];
        st_wr_row = cur_q.rbuf;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (accept) begin
                    if (!cur_q.open_vld) begin
                        // Nothing open: activate only.
                        nxt_d.kind = KIND_MISS;
                        nxt_d.cnt  = MISS_CNT;
                        act_row    = row_t'(st_rd_row);
                    end else if (cur_q.open_row == req_row) begin
                        nxt_d.kind = KIND_HIT;
                        nxt_d.cnt  = HIT_CNT;
                    end else begin
                        // Write the buffer back, then copy the new row in.
                        nxt_d.kind = KIND_CONFLICT;
                        nxt_d.cnt  = CONF_CNT;
                        st_wr_en   = 1'b1;
                        if (cur_q.open_row[IDX_W-1:0] != req_row[IDX_W-1:0]) begin
                            act_row = row_t'(st_rd_row);
                        end
                    end
                    nxt_d.rdata = req_write ? req_wdata : act_row[req_col];
                    if (req_write) begin
                        act_row[req_col] = req_wdata;
                    end
                    nxt_d.rbuf     = act_row;
                    nxt_d.open_vld = 1'b1;
                    nxt_d.open_row = req_row;
                    nxt_d.state    = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (cur_q.cnt == '0) begin
                    nxt_d.state = ST_RESP;
                end else begin
                    nxt_d.cnt = cur_q.cnt - LAT_W'(1);
                end
            end
            ST_RESP: begin
                nxt_d.state = ST_IDLE;
            end
            default: begin
                nxt_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_ready     = (cur_q.state == ST_IDLE);
    assign rsp_valid     = (cur_q.state == ST_RESP);
    assign rsp_rdata     = cur_q.rdata;
    assign rsp_kind      = cur_q.kind;
    assign hit_done      = rsp_valid && (cur_q.kind == KIND_HIT);
    assign conflict_done = rsp_valid && (cur_q.kind == KIND_CONFLICT);

    // Independent cycle count since the accepting edge, used only by assertions.
    logic [LAT_W:0] elap_q;
    logic           done_once_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elap_q      <= '0;
            done_once_q <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                elap_q <= '0;
            end else if (elap_q != '1) begin
                elap_q <= elap_q + 1'b1;
            end
            if (rsp_valid) begin
                done_once_q <= 1'b1;
            end
        end
    end

    assert_miss_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == KIND_MISS) |-> elap_q == (LAT_W+1)'(MISS_LAT));

    assert_miss_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == KIND_MISS) |-> !done_once_q);

    assert_hit_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == KIND_HIT) |-> elap_q == (LAT_W+1)'(HIT_LAT));

    assert_conflict_lat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == KIND_CONFLICT) |-> elap_q == (LAT_W+1)'(CONF_LAT));

    assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

endmodule

// File: rtl/dram_bank_model.sv
module dram_bank_model #(
    parameter int ROW_W       = 15,
    parameter int COL_W       = 2,
    parameter int DATA_W      = 8,
    parameter int STORE_IDX_W = 3,
    parameter int HIT_LAT     = 2,
    parameter int ACT_LAT     = 3,
    parameter int PRE_LAT     = 4,
    parameter int CNT_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [1:0]        rsp_kind,
    input  logic              cnt_clear,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  conflict_count
);
    localparam int ROW_BITS = DATA_W << COL_W;

    logic [STORE_IDX_W-1:0] st_rd_idx, st_wr_idx;
    logic [ROW_BITS-1:0]    st_rd_row, st_wr_row;
    logic                   st_wr_en;
    logic                   hit_done, conflict_done;
    logic [1:0]             done_w;
    logic [CNT_W-1:0]       cnt_w [2];

    dbm_row_store #(
        .IDX_W    (STORE_IDX_W),
        .ROW_BITS (ROW_BITS)
    ) i_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (st_rd_idx),
        .rd_row (st_rd_row),
        .wr_en  (st_wr_en),
        .wr_idx (st_wr_idx),
        .wr_row (st_wr_row)
    );

    dbm_bank_ctrl #(
        .ROW_W   (ROW_W),
        .COL_W   (COL_W),
        .DATA_W  (DATA_W),
        .IDX_W   (STORE_IDX_W),
        .HIT_LAT (HIT_LAT),
        .ACT_LAT (ACT_LAT),
        .PRE_LAT (PRE_LAT)
    ) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_row       (req_row),
        .req_col       (req_col),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .rsp_kind      (rsp_kind),
        .st_rd_idx     (st_rd_idx),
        .st_rd_row     (st_rd_row),
        .st_wr_en      (st_wr_en),
        .st_wr_idx     (st_wr_idx),
        .st_wr_row     (st_wr_row),
        .hit_done      (hit_done),
        .conflict_done (conflict_done)
    );

    assign done_w = {conflict_done, hit_done};

    for (genvar g = 0; g < 2; g++) begin : g_cnt
        dbm_sat_counter #(
            .CNT_W (CNT_W)
        ) i_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clear),
            .inc   (done_w[g]),
            .count (cnt_w[g])
        );
    end

    assign hit_count      = cnt_w[0];
    assign conflict_count = cnt_w[1];

endmodule

// File: tb/test_dram_bank_model.sv
`timescale 1ns/1ps
module test_dram_bank_model;
    localparam int HIT_LAT = 2, ACT_LAT = 3, PRE_LAT = 4;
    localparam int CNT_MAX = 15;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, cnt_clear = 1'b0;
    logic [14:0] req_row = '0;
    logic [1:0]  req_col = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [1:0]  rsp_kind;
    logic [3:0]  hit_count, conflict_count;

    int n_checks = 0, n_fail = 0;

    // Bench model
    bit      m_open = 0;
    int      m_row = 0;
    byte     m_cell [8][4];
    int      m_hits = 0, m_confs = 0;
    bit      clear_on_rsp = 0;
    bit      poke_en = 0;
    int      poke_row = 0;

    always #10 clk = ~clk;

    dram_bank_model i_dram_bank_model (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_row(req_row), .req_col(req_col),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_kind(rsp_kind), .cnt_clear(cnt_clear), .hit_count(hit_count),
        .conflict_count(conflict_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic access(input bit wr, input int row, input int col,
                          input int wd, input string req);
        int exp_kind, exp_lat, exp_data, lat, idx;
        idx = row % 8;
        if (!m_open) begin exp_kind = 1; exp_lat = ACT_LAT + HIT_LAT; end
        else if (m_row == row) begin exp_kind = 0; exp_lat = HIT_LAT; end
        else begin exp_kind = 2; exp_lat = PRE_LAT + ACT_LAT + HIT_LAT; end
        exp_data = wr ? (wd & 255) : int'(m_cell[idx][col]) & 255;
        if (wr) m_cell[idx][col] = byte'(wd);
        m_open = 1; m_row = row;

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_row = 15'(row);
        req_col = 2'(col); req_wdata = 8'(wd);
        @(posedge clk);
        @(negedge clk);
        if (poke_en) begin
            req_row = 15'(poke_row); req_write = 1; req_wdata = 8'hEE;
        end else begin
            req_valid = 0;
        end
        chk(req_ready == 0, "R6", "ready while busy", req_ready, 0);
        lat = 0;
        while (!rsp_valid && lat < 64) begin
            @(negedge clk);
            lat++;
            req_valid = 0;
        end
        chk(lat == exp_lat, req, "latency", lat, exp_lat);
        chk(rsp_kind == 2'(exp_kind), req, "kind", rsp_kind, exp_kind);
        chk(rsp_rdata == 8'(exp_data), "R8", "rdata", rsp_rdata, exp_data);
        if (clear_on_rsp) cnt_clear = 1;
        @(negedge clk);
        cnt_clear = 0;
        if (clear_on_rsp) begin
            m_hits = 0; m_confs = 0;
        end else begin
            if (exp_kind == 0 && m_hits < CNT_MAX) m_hits++;
            if (exp_kind == 2 && m_confs < CNT_MAX) m_confs++;
        end
        chk(rsp_valid == 0, "R7", "pulse length", rsp_valid, 0);
        chk(req_ready == 1, "R6", "ready after rsp", req_ready, 1);
        chk(hit_count == 4'(m_hits), "R11", "hit_count", hit_count, m_hits);
        chk(conflict_count == 4'(m_confs), "R11", "conflict_count",
            conflict_count, m_confs);
    endtask

    task automatic t_reset();
        chk(req_ready == 1, "R1", "ready at reset", req_ready, 1);
        chk(rsp_valid == 0, "R1", "rsp_valid at reset", rsp_valid, 0);
        chk(hit_count == 0 && conflict_count == 0, "R1", "counters at reset",
            hit_count + conflict_count, 0);
    endtask

    task automatic t_first_miss();
        access(0, 3, 1, 0, "R2");          // nothing open -> miss, reads 0 (R1)
    endtask

    task automatic t_hit_rw();
        access(1, 3, 1, 8'hA5, "R3");
        access(0, 3, 1, 0, "R3");          // R8 read-after-write
        access(0, 3, 0, 0, "R3");
    endtask

    task automatic t_conflict();
        access(0, 7, 0, 0, "R4");
        access(0, 7, 2, 0, "R4");          // row 7 now open -> hit
    endtask

    task automatic t_writeback();
        access(0, 3, 1, 0, "R9");          // A5 must have been written back
    endtask

    task automatic t_row_msb();
        access(1, 3, 2, 8'h3C, "R5");
        access(0, 16'h4003, 2, 0, "R5");   // differs in bit 14 only; R10 alias
        access(1, 16'h4003, 2, 8'h77, "R10");
        access(0, 3, 2, 0, "R10");
    endtask

    task automatic t_busy_ignore();
        poke_en = 1; poke_row = 5;
        access(0, 6, 3, 0, "R6");          // conflict, poke during wait
        poke_en = 0;
        begin
            int extra = 0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (rsp_valid) extra++;
            end
            chk(extra == 0, "R6", "responses from ignored request", extra, 0);
        end
        access(0, 6, 0, 0, "R6");          // still row 6 open -> hit
        access(0, 5, 0, 0, "R6");          // poke data not written
    endtask

    task automatic t_counters();
        for (int i = 0; i < 18; i++) access(0, 5, i % 4, 0, "R11");
        chk(hit_count == 4'(CNT_MAX), "R11", "saturated hits", hit_count, CNT_MAX);
        clear_on_rsp = 1;
        access(0, 5, 1, 0, "R12");         // clear in same cycle as increment
        clear_on_rsp = 0;
        chk(hit_count == 0 && conflict_count == 0, "R12", "after clear",
            hit_count + conflict_count, 0);
        access(0, 9, 1, 0, "R11");         // conflict counts from 0 again
    endtask

    initial begin
        #(20 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 4; c++) m_cell[r][c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_first_miss();
        t_hit_rw();
        t_conflict();
        t_writeback();
        t_row_msb();
        t_busy_ignore();
        t_counters();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule